// File: doc/BRIEF.md
# I2C Register Read Sequencer over a Bit-Level Control Register

This block performs one combined-format I2C register read without touching any pins itself. It drives the bus indirectly: every change of the clock or data line is a 16-bit word written to a single serial-bus control register. Every time the data line must be observed, the block reads a status word and looks at one bit of it. Both the control write and the status read use a strobe/ready handshake. After every accepted control write, the block keeps a fixed minimum gap before it issues the next bus operation.

A single `startPulse` latches a pre-shifted device address and a register index. The block then writes the register index to the device, issues a repeated start with the read address (the device address plus one), and clocks in one data byte. It answers that byte with a not-acknowledge, stops the bus, and finally hands the lines back to the fast serial mode. At the end it presents the byte, pulses `donePulse` and reports whether any acknowledge was missing.

Top module: `i2cRegReadSeq`

## Requirements
- R1: After reset no strobe is asserted, and `donePulse`, `ackErr`, `busy` and `rdByte` are all zero.
- R2: The transaction is framed as follows. It opens with write 0x13, then start (0x11, 0x10), address byte, ack, index byte, ack, stop (0x10, 0x11, 0x13), start, read-address byte, ack, data byte, not-ack, stop. The last write is 0x30. That makes 122 bus operations in all.
- R3: Each transmitted bit is three writes: 0x10|d, 0x11|d, 0x10|d, with d = 0x02 for a one. Bytes go MSB first. The three bytes are the device address, the register index and the device address plus one.
- R4: An acknowledge phase writes 0x12, writes 0x13, reads the status word and writes 0x12. If status bit 3 is high at that read, `ackErr` is set.
- R5: Each received bit writes 0x13, reads the status word and writes 0x12. Status bit 3 is shifted in MSB first. The assembled byte appears on `rdByte` when `donePulse` is high and holds until the next transaction ends.
- R6: After the data byte the block sends not-acknowledge, 0x13 then 0x12, and never drives the data line low there.
- R7: Between the acceptance of a control write and the next asserted strobe there are at least GAP_CYCLES cycles with no strobe.
- R8: A strobe and its write word stay unchanged until ready is seen. The control-write strobe and the status-read strobe are never high together.
- R9: A missing acknowledge does not stop the sequence. `ackErr` stays set after completion and clears only when the next transaction starts.
- R10: A `startPulse` while `busy` is high is ignored. The running transaction and its bytes are unaffected.
- R11: `donePulse` is a single-cycle pulse in the cycle after the final 0x30 write is accepted. In that same cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a read when idle |
| devAddr | input | 8 | Device address already shifted left by one, write form |
| regIdx | input | 8 | Register index to read |
| ctrlWrStb | output | 1 | Control-register write request |
| ctrlWrData | output | 16 | Control word (bit 4 drive enable, bit 1 data, bit 0 clock) |
| ctrlWrRdy | input | 1 | Control write accepted |
| statRdStb | output | 1 | Status-register read request |
| statRdData | input | 16 | Status word; bit 3 is the sampled data line |
| statRdRdy | input | 1 | Status read accepted, data valid |
| rdByte | output | 8 | Byte read from the device |
| donePulse | output | 1 | One-cycle completion pulse |
| ackErr | output | 1 | A missing acknowledge was seen |
| busy | output | 1 | Transaction in progress |

## Verification
The bench builds the block with GAP_CYCLES = 4 and 8-bit bytes. At these values the whole 122-operation transaction can be compared operation by operation against a list computed in the bench, for every transaction. The responder's ready latency is swept from 0 to 3 cycles, which exposes both the gap rule and the hold-until-ready rule. The status word returns all ones apart from bit 3, so a read of the wrong bit is visible. Addresses and indices walk single ones, data bytes cover spread patterns, and missing acknowledges are injected in each of the three ack phases.

// File: rtl/i2cRdSeqPkg.sv
package i2cRdSeqPkg;
  localparam int CTRL_W = 16;

  localparam logic [CTRL_W-1:0] CW_EN   = 16'h0010;
  localparam logic [CTRL_W-1:0] CW_SDA  = 16'h0002;
  localparam logic [CTRL_W-1:0] CW_SCL  = 16'h0001;
  localparam logic [CTRL_W-1:0] CW_FAST = 16'h0030;

  // Enum order is the transaction order; the control steps through it.
  typedef enum logic [3:0] {
    SegIdle, SegPre, SegStartA, SegTxAddr, SegAckA, SegTxReg, SegAckB,
    SegStopA, SegStartB, SegTxAddrRd, SegAckC, SegRxData, SegNack,
    SegStopB, SegRestore
  } segE;

  typedef enum logic [1:0] {TxSelAddr, TxSelReg, TxSelAddrRd} txSelE;

  typedef struct packed {
    logic              req;
    logic              isRead;
    logic [CTRL_W-1:0] word;
    logic              useTxBit;
    logic              sampleAck;
    logic              sampleBit;
    logic              txLoad;
    txSelE             txSel;
    logic              txShift;
    logic              clrErr;
    logic              capture;
    logic              finish;
  } seqCmdT;
endpackage

// File: rtl/i2cRdSeqCtrl.sv
module i2cRdSeqCtrl
  import i2cRdSeqPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   opDone,
  output seqCmdT cmd,
  output logic   busy
);
  localparam int BIT_CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  segE seg, nextSeg;
  logic [1:0] sub, lastSub;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic repeatSeg, stepEnd, segEnd;

  function automatic logic isTxSeg(segE s);
    return (s == SegTxAddr) || (s == SegTxReg) || (s == SegTxAddrRd);
  endfunction

  always_comb begin
    repeatSeg = 1'b0;
    case (seg)
      SegStartA, SegStartB, SegNack:    lastSub = 2'd1;
      SegTxAddr, SegTxReg, SegTxAddrRd,
      SegRxData: begin
        lastSub   = 2'd2;
        repeatSeg = 1'b1;
      end
      SegAckA, SegAckB, SegAckC:        lastSub = 2'd3;
      SegStopA, SegStopB:               lastSub = 2'd2;
      default:                          lastSub = 2'd0;
    endcase
  end

  assign nextSeg = (seg == SegRestore) ? SegIdle : segE'(4'(seg) + 4'd1);
  assign stepEnd = opDone && (sub == lastSub);
  assign segEnd  = stepEnd && (!repeatSeg || (bitCnt == LAST_BIT));
  assign busy    = (seg != SegIdle);

  always_comb begin
    cmd = '0;
    cmd.req = busy;
    case (seg)
      SegPre:     cmd.word = CW_EN | CW_SDA | CW_SCL;
      SegStartA, SegStartB:
        cmd.word = (sub == 2'd0) ? (CW_EN | CW_SCL) : CW_EN;
      SegTxAddr, SegTxReg, SegTxAddrRd: begin
        cmd.word     = (sub == 2'd1) ? (CW_EN | CW_SCL) : CW_EN;
        cmd.useTxBit = 1'b1;
      end
      SegAckA, SegAckB, SegAckC: begin
        case (sub)
          2'd1:    cmd.word = CW_EN | CW_SDA | CW_SCL;
          2'd2: begin
            cmd.isRead    = 1'b1;
            cmd.sampleAck = 1'b1;
          end
          default: cmd.word = CW_EN | CW_SDA;
        endcase
      end
      SegStopA, SegStopB: begin
        case (sub)
          2'd0:    cmd.word = CW_EN;
          2'd1:    cmd.word = CW_EN | CW_SCL;
          default: cmd.word = CW_EN | CW_SDA | CW_SCL;
        endcase
      end
      SegRxData: begin
        case (sub)
          2'd0:    cmd.word = CW_EN | CW_SDA | CW_SCL;
          2'd1: begin
            cmd.isRead    = 1'b1;
            cmd.sampleBit = 1'b1;
          end
          default: cmd.word = CW_EN | CW_SDA;
        endcase
      end
      SegNack:    cmd.word = (sub == 2'd0) ? (CW_EN | CW_SDA | CW_SCL) : (CW_EN | CW_SDA);
      SegRestore: cmd.word = CW_FAST;
      default:    cmd.word = '0;
    endcase
    cmd.txLoad  = segEnd && isTxSeg(nextSeg);
    cmd.txSel   = (nextSeg == SegTxReg) ? TxSelReg :
                  (nextSeg == SegTxAddrRd) ? TxSelAddrRd : TxSelAddr;
    cmd.txShift = opDone && isTxSeg(seg) && (sub == 2'd2);
    cmd.clrErr  = (seg == SegIdle) && startPulse;
    cmd.capture = (seg == SegIdle) && startPulse;
    cmd.finish  = segEnd && (seg == SegRestore);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seg    <= SegIdle;
      sub    <= '0;
      bitCnt <= '0;
    end else if (seg == SegIdle) begin
      if (startPulse) begin
        seg    <= SegPre;
        sub    <= '0;
        bitCnt <= '0;
      end
    end else if (opDone) begin
      if (sub == lastSub) begin
        sub <= '0;
        if (repeatSeg && (bitCnt != LAST_BIT)) begin
          bitCnt <= bitCnt + 1'b1;
        end else begin
          bitCnt <= '0;
          seg    <= nextSeg;
        end
      end else begin
        sub <= sub + 2'd1;
      end
    end
  end

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seg != SegIdle && seg != SegPre) |=> (seg != SegPre));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seg == SegIdle) |-> !opDone);
endmodule

// File: rtl/i2cRdSeqPath.sv
module i2cRdSeqPath
  import i2cRdSeqPkg::*;
#(
  parameter int GAP_CYCLES   = 4,
  parameter int BYTE_W       = 8,
  parameter int SDA_STAT_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmdT            cmd,
  input  logic [BYTE_W-1:0] devAddr,
  input  logic [BYTE_W-1:0] regIdx,
  output logic              ctrlWrStb,
  output logic [CTRL_W-1:0] ctrlWrData,
  input  logic              ctrlWrRdy,
  output logic              statRdStb,
  input  logic              sdaLevel,
  input  logic              statRdRdy,
  output logic              opDone,
  output logic [BYTE_W-1:0] rdByte,
  output logic              donePulse,
  output logic              ackErr
);
  localparam int GAP_W = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES);

  logic [BYTE_W-1:0] addrQ, regQ, txQ, rxQ, rdByteQ;
  logic [CTRL_W-1:0] wordQ;
  logic [GAP_W-1:0]  gapCnt;
  logic wrStbQ, rdStbQ, doneQ, ackErrQ;
  logic wrAcc, rdAcc, issue;

  assign wrAcc  = wrStbQ && ctrlWrRdy;
  assign rdAcc  = rdStbQ && statRdRdy;
  assign opDone = wrAcc || rdAcc;
  assign issue  = cmd.req && !wrStbQ && !rdStbQ && (gapCnt == '0);

  // Bus operation engine with handshake and write gap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrStbQ <= 1'b0;
      rdStbQ <= 1'b0;
      wordQ  <= '0;
      gapCnt <= '0;
    end else begin
      if (wrAcc) wrStbQ <= 1'b0;
      if (rdAcc) rdStbQ <= 1'b0;
      if (issue) begin
        if (cmd.isRead) begin
          rdStbQ <= 1'b1;
        end else begin
          wrStbQ <= 1'b1;
          wordQ  <= cmd.word | ((cmd.useTxBit && txQ[BYTE_W-1]) ? CW_SDA : '0);
        end
      end
      if (wrAcc)              gapCnt <= GAP_LOAD;
      else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
    end
  end

  // Byte shifters, error flag and result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      regQ    <= '0;
      txQ     <= '0;
      rxQ     <= '0;
      rdByteQ <= '0;
      doneQ   <= 1'b0;
      ackErrQ <= 1'b0;
    end else begin
      if (cmd.capture) begin
        addrQ <= devAddr;
        regQ  <= regIdx;
        rxQ   <= '0;
      end
      if (cmd.txLoad) begin
        case (cmd.txSel)
          TxSelReg:    txQ <= regQ;
          TxSelAddrRd: txQ <= addrQ + 1'b1;
          default:     txQ <= addrQ;
        endcase
      end else if (cmd.txShift) begin
        txQ <= {txQ[BYTE_W-2:0], 1'b0};
      end
      if (rdAcc && cmd.sampleBit) rxQ <= {rxQ[BYTE_W-2:0], sdaLevel};
      if (cmd.clrErr)                           ackErrQ <= 1'b0;
      else if (rdAcc && cmd.sampleAck && sdaLevel) ackErrQ <= 1'b1;
      doneQ <= cmd.finish;
      if (cmd.finish) rdByteQ <= rxQ;
    end
  end

  assign ctrlWrStb  = wrStbQ;
  assign statRdStb  = rdStbQ;
  assign ctrlWrData = wordQ;
  assign rdByte     = rdByteQ;
  assign donePulse  = doneQ;
  assign ackErr     = ackErrQ;

  // Cycles since the last accepted write, saturating at the gap value
  logic [GAP_W-1:0] sinceWr;
  logic             wrStbD;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceWr <= GAP_LOAD;
      wrStbD  <= 1'b0;
    end else begin
      wrStbD <= wrStbQ;
      if (wrAcc)                   sinceWr <= '0;
      else if (sinceWr != GAP_LOAD) sinceWr <= sinceWr + 1'b1;
    end
  end

  // R7
  write_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStbQ && !wrStbD) |-> (sinceWr == GAP_LOAD));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStbQ && !ctrlWrRdy) |=> (wrStbQ && $stable(wordQ)));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStbQ && rdStbQ));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackErrQ) |-> $past(cmd.clrErr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
endmodule

// File: rtl/i2cRegReadSeq.sv
module i2cRegReadSeq
  import i2cRdSeqPkg::*;
#(
  parameter int GAP_CYCLES   = 4,
  parameter int BYTE_W       = 8,
  parameter int SDA_STAT_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [BYTE_W-1:0] devAddr,
  input  logic [BYTE_W-1:0] regIdx,
  output logic              ctrlWrStb,
  output logic [CTRL_W-1:0] ctrlWrData,
  input  logic              ctrlWrRdy,
  output logic              statRdStb,
  input  logic [CTRL_W-1:0] statRdData,
  input  logic              statRdRdy,
  output logic [BYTE_W-1:0] rdByte,
  output logic              donePulse,
  output logic              ackErr,
  output logic              busy
);
  seqCmdT cmd;
  logic   opDone;
  logic   unusedStatBits;

  assign unusedStatBits = ^statRdData;

  i2cRdSeqCtrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .opDone     (opDone),
    .cmd        (cmd),
    .busy       (busy)
  );

  i2cRdSeqPath #(
    .GAP_CYCLES   (GAP_CYCLES),
    .BYTE_W       (BYTE_W),
    .SDA_STAT_BIT (SDA_STAT_BIT)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .devAddr    (devAddr),
    .regIdx     (regIdx),
    .ctrlWrStb  (ctrlWrStb),
    .ctrlWrData (ctrlWrData),
    .ctrlWrRdy  (ctrlWrRdy),
    .statRdStb  (statRdStb),
    .sdaLevel   (statRdData[SDA_STAT_BIT]),
    .statRdRdy  (statRdRdy),
    .opDone     (opDone),
    .rdByte     (rdByte),
    .donePulse  (donePulse),
    .ackErr     (ackErr)
  );
endmodule

// File: tb/tb_i2cRegReadSeq.sv
module tb_i2cRegReadSeq;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [7:0] devAddr = '0, regIdx = '0;
  logic ctrlWrStb, statRdStb, donePulse, ackErr, busy;
  logic [15:0] ctrlWrData;
  logic ctrlWrRdy = 1'b0, statRdRdy = 1'b0;
  logic [15:0] statRdData = 16'hFFFF;
  logic [7:0] rdByte;

  always #5 clk = ~clk;

  i2cRegReadSeq #(.GAP_CYCLES(GAP), .BYTE_W(8), .SDA_STAT_BIT(3)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .devAddr(devAddr),
    .regIdx(regIdx), .ctrlWrStb(ctrlWrStb), .ctrlWrData(ctrlWrData),
    .ctrlWrRdy(ctrlWrRdy), .statRdStb(statRdStb), .statRdData(statRdData),
    .statRdRdy(statRdRdy), .rdByte(rdByte), .donePulse(donePulse),
    .ackErr(ackErr), .busy(busy)
  );

  int checks = 0, fails = 0;
  int lat = 0;
  logic [7:0] respData = '0;
  logic [2:0] respAckMiss = '0;
  int rdIdx = 0, doneCnt = 0, gapViol = 0, holdViol = 0;
  logic [16:0] gotOp [0:255];
  int gotN = 0;
  logic [16:0] expOp [0:255];
  int expTag [0:255];
  int expN = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Responder: decides ready at negedges, logs every accepted operation
  initial begin : busModel
    int waitCnt = 0, lowCnt = GAP;
    bit prevWr = 0;
    logic [15:0] firstWord = '0;
    forever begin
      @(negedge clk);
      if (donePulse) doneCnt++;
      ctrlWrRdy = 1'b0;
      statRdRdy = 1'b0;
      if (ctrlWrStb && !prevWr) begin
        if (lowCnt < GAP) gapViol++;
        firstWord = ctrlWrData;
      end
      if (ctrlWrStb && ctrlWrData != firstWord) holdViol++;
      if (!ctrlWrStb && !statRdStb) lowCnt++;
      prevWr = ctrlWrStb;
      if (ctrlWrStb || statRdStb) begin
        if (waitCnt >= lat) begin
          waitCnt = 0;
          if (ctrlWrStb) begin
            ctrlWrRdy = 1'b1;
            gotOp[gotN] = {1'b0, ctrlWrData};
            gotN++;
            lowCnt = 0;
            prevWr = 0;
          end else begin
            bit lvl;
            if (rdIdx < 3) lvl = respAckMiss[rdIdx];
            else lvl = respData[7 - (rdIdx - 3)];
            statRdData = lvl ? 16'hFFFF : 16'hFFF7;
            statRdRdy = 1'b1;
            gotOp[gotN] = {1'b1, 16'h0000};
            gotN++;
            rdIdx++;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic pushW(input logic [15:0] w, input int tag);
    expOp[expN] = {1'b0, w}; expTag[expN] = tag; expN++;
  endtask
  task automatic pushR(input int tag);
    expOp[expN] = {1'b1, 16'h0000}; expTag[expN] = tag; expN++;
  endtask
  task automatic pushByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic [15:0] d = b[i] ? 16'h0002 : 16'h0000;
      pushW(16'h0010 | d, 3); pushW(16'h0011 | d, 3); pushW(16'h0010 | d, 3);
    end
  endtask
  task automatic pushAck();
    pushW(16'h0012, 4); pushW(16'h0013, 4); pushR(4); pushW(16'h0012, 4);
  endtask
  task automatic buildExp(input logic [7:0] a, input logic [7:0] r);
    expN = 0;
    pushW(16'h0013, 2);
    pushW(16'h0011, 2); pushW(16'h0010, 2);
    pushByte(a); pushAck();
    pushByte(r); pushAck();
    pushW(16'h0010, 2); pushW(16'h0011, 2); pushW(16'h0013, 2);
    pushW(16'h0011, 2); pushW(16'h0010, 2);
    pushByte(a + 8'd1); pushAck();
    for (int i = 0; i < 8; i++) begin
      pushW(16'h0013, 5); pushR(5); pushW(16'h0012, 5);
    end
    pushW(16'h0013, 6); pushW(16'h0012, 6);
    pushW(16'h0010, 2); pushW(16'h0011, 2); pushW(16'h0013, 2);
    pushW(16'h0030, 2);
  endtask

  task automatic runTx(input logic [7:0] a, input logic [7:0] r,
                       input logic [7:0] d, input logic [2:0] miss,
                       input int latency, input bit midStart, input bit prevErr);
    int errs [2:6];
    int firstAct [2:6], firstExp [2:6];
    int cyc = 0;
    logic [7:0] oldByte = rdByte;
    for (int t = 2; t <= 6; t++) begin errs[t] = 0; firstAct[t] = 0; firstExp[t] = 0; end
    @(negedge clk);
    // R9: an earlier missing ack is still reported until this start
    if (prevErr) chk(ackErr == 1'b1, "R9", "ackErr held", ackErr, 1);
    lat = latency; respData = d; respAckMiss = miss;
    rdIdx = 0; gotN = 0; doneCnt = 0; gapViol = 0; holdViol = 0;
    buildExp(a, r);
    devAddr = a; regIdx = r; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(ackErr == 1'b0, "R9", "ackErr cleared at start", ackErr, 0);
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    while (doneCnt == 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 60) begin
        devAddr = ~a; regIdx = ~r; startPulse = 1'b1;   // R10
      end else begin
        startPulse = 1'b0; devAddr = a; regIdx = r;
      end
    end
    chk(rdByte == d, "R5", "rdByte", rdByte, d);
    chk(ackErr == (miss != 3'b000), "R4", "ackErr", ackErr, (miss != 3'b000));
    chk(busy == 1'b0, "R11", "busy at done", busy, 0);
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, "R11", "done pulse count", doneCnt, 1);
    chk(rdByte == d, "R5", "rdByte held", rdByte, d);
    chk(gotN == expN, "R2", "operation count", gotN, expN);
    for (int i = 0; i < expN; i++) begin
      logic [16:0] g = (i < gotN) ? gotOp[i] : 17'h1FFFF;
      if (g != expOp[i]) begin
        if (errs[expTag[i]] == 0) begin
          firstAct[expTag[i]] = g; firstExp[expTag[i]] = expOp[i];
        end
        errs[expTag[i]]++;
      end
    end
    chk(errs[2] == 0, "R2", "framing ops", firstAct[2], firstExp[2]);
    chk(errs[3] == 0, "R3", "byte send ops", firstAct[3], firstExp[3]);
    chk(errs[4] == 0, "R4", "ack phase ops", firstAct[4], firstExp[4]);
    chk(errs[5] == 0, "R5", "receive ops", firstAct[5], firstExp[5]);
    chk(errs[6] == 0, "R6", "not-ack ops", firstAct[6], firstExp[6]);
    chk(gapViol == 0, "R7", "write gap violations", gapViol, 0);
    chk(holdViol == 0, "R8", "word changed while waiting", holdViol, 0);
    if (midStart) chk(rdByte == d && errs[3] == 0, "R10", "restart ignored", rdByte, d);
    if (oldByte == rdByte && oldByte != d) chk(1'b0, "R5", "rdByte updated", rdByte, d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : mainSeq
    bit lastErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ctrlWrStb == 1'b0, "R1", "ctrlWrStb", ctrlWrStb, 0);
    chk(statRdStb == 1'b0, "R1", "statRdStb", statRdStb, 0);
    chk(donePulse == 1'b0, "R1", "donePulse", donePulse, 0);
    chk(ackErr == 1'b0, "R1", "ackErr", ackErr, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rdByte == 8'h00, "R1", "rdByte", rdByte, 0);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a = (8'h02 << (i % 7)) ^ ((i / 7) == 1 ? 8'hF0 : 8'h00);
      logic [7:0] r = 8'h01 << (i % 8);
      logic [7:0] d = 8'(i * 73 + 5);
      logic [2:0] miss = (i % 5 == 3) ? 3'(1 << (i % 3)) : 3'b000;
      if (i == 0) d = 8'h00;
      if (i == 1) d = 8'hFF;
      if (i == 2) begin a = 8'hFE; r = 8'hFF; end
      runTx(a, r, d, miss, i % 4, (i % 4) == 1, lastErr);
      lastErr = (miss != 3'b000);
      if (lastErr) repeat (20) @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule